// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 16-bit successive-approximation converter. Two active-low strobes, a chip select and a read/convert line, are combined so that a conversion starts when the pair becomes jointly low. It does not matter which of the two falls last. Both strobes pass through a synchroniser before the start edge is detected. During a conversion the block presents a trial word to an external capacitive DAC and reads back a one-bit comparator decision. It resolves one bit per clock cycle, starting at the most significant bit.

When the last bit has been decided, the result goes into an output latch and the active-low busy flag is released. The latched word can be read from a 16-bit bus. The bus has an output enable so that a pad ring can tri-state it, and a byte-select input exchanges its two halves. A parameter chooses the output coding: straight binary for a unipolar input range, or two's complement for a bipolar one. If both strobes are still low on the cycle after busy rises, a new conversion begins at once.

Top module: `sarConvCore`

## Requirements
- R1: With `csN` held low, a falling edge on `rcN` starts a conversion, and `busyN` goes low within a few clock cycles.
- R2: With `rcN` held low, a falling edge on `csN` starts a conversion. A fall of `rcN` while `csN` is high starts nothing.
- R3: In the first busy cycle `dacWord` equals 16'h8000, which is the cleared register with only the MSB trial bit set. Bits are then decided from MSB to LSB. A bit is kept when `cmpKeep` is 1, which means the trial word is not above the input.
- R4: `busyN` stays low for exactly W+1 clock cycles: 16 decision cycles and one latch cycle. The new word is on `dataOut` from the cycle in which `busyN` is high again.
- R5: Start edges that arrive while `busyN` is low are ignored. The conversion keeps its length and result, and no second conversion follows.
- R6: If `csN` and `rcN` are both low when the block is about to go idle, `busyN` is high for exactly one cycle and a new conversion then starts.
- R7: `busOe` is 1 only when `csN` is low and `rcN` is high. Otherwise it is 0.
- R8: With `byteSel` at 0, `dataOut[15:8]` carries result bits 15..8. With `byteSel` at 1 the two byte halves are exchanged.
- R9: With BIPOLAR=0 the result is the straight-binary SAR word. With BIPOLAR=1 the SAR word has its MSB inverted, which gives two's complement.
- R10: After reset `busyN` is 1, `dacWord` is 0 and the output latch holds 0.
- R11: While a conversion runs, `dataOut` keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one bit decision per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select strobe |
| rcN | input | 1 | Read (high) / convert (low) strobe |
| byteSel | input | 1 | Swap upper and lower bus halves when 1 |
| cmpKeep | input | 1 | Comparator decision: 1 keeps the current trial bit |
| dacWord | output | 16 | Trial word for the external DAC |
| busyN | output | 1 | Low while a conversion is in progress |
| dataOut | output | 16 | Latched result, possibly byte-swapped |
| busOe | output | 1 | Drive enable for the external three-state bus |

## Verification
The hardest case to reach is the self-retrigger. Both strobes must stay low through the whole conversion, and the bench has to observe that busy is high for exactly one cycle before a fresh conversion starts. The bench holds the pair low, changes the analog value in the one idle cycle, and then checks that the second result follows the new value. The bench's comparator model makes a live comparison against a target value. Because of that, a restart or a lost step in the bit order would show up as a wrong result, and a busy period of the wrong length would be caught too.

// File: rtl/sarPkg.sv
package sarPkg;
  typedef struct packed {
    logic clearSar;
    logic stepBit;
    logic loadOut;
  } sarStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_LOAD = 2'd2
  } sarState_t;
endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarPkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW       = $clog2(W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rcN,
  output sarStrobe_t      strobe,
  output logic [IDXW-1:0] bitIdx,
  output logic            busyN
);
  logic [SYNC_STAGES-1:0] syncCs, syncRc;
  logic startLvl, prevLvl, startFall, retrig, justDone, goConv;
  sarState_t state;

  // two-flop (parameterised) synchronisers for each strobe
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncCs <= '1;
          syncRc <= '1;
        end else begin
          syncCs <= csN;
          syncRc <= rcN;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncCs <= '1;
          syncRc <= '1;
        end else begin
          syncCs <= {syncCs[SYNC_STAGES-2:0], csN};
          syncRc <= {syncRc[SYNC_STAGES-2:0], rcN};
        end
      end
    end
  endgenerate

  // combined strobe: low only when both are low
  assign startLvl  = syncCs[SYNC_STAGES-1] | syncRc[SYNC_STAGES-1];
  assign startFall = prevLvl & ~startLvl;
  assign retrig    = justDone & ~startLvl;
  assign goConv    = (state == ST_IDLE) && (startFall || retrig);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl  <= 1'b1;
      state    <= ST_IDLE;
      bitIdx   <= '0;
      busyN    <= 1'b1;
      justDone <= 1'b0;
    end else begin
      prevLvl  <= startLvl;
      justDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (goConv) begin
            state  <= ST_CONV;
            bitIdx <= IDXW'(W-1);
            busyN  <= 1'b0;
          end
        end
        ST_CONV: begin
          if (bitIdx == '0) state <= ST_LOAD;
          else              bitIdx <= bitIdx - 1'b1;
        end
        ST_LOAD: begin
          state    <= ST_IDLE;
          busyN    <= 1'b1;
          justDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearSar = goConv;
    strobe.stepBit  = (state == ST_CONV);
    strobe.loadOut  = (state == ST_LOAD);
  end
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int W       = 16,
  parameter bit BIPOLAR = 1'b0,
  localparam int IDXW   = $clog2(W),
  localparam int HALF   = W / 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  sarStrobe_t      strobe,
  input  logic [IDXW-1:0] bitIdx,
  input  logic            cmpKeep,
  input  logic            byteSel,
  output logic [W-1:0]    trialWord,
  output logic [W-1:0]    outWord
);
  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sarReg, nextSar, coded, outLatch;

  always_comb begin
    nextSar = sarReg;
    for (int i = 0; i < W; i++) begin
      if (bitIdx == IDXW'(i)) nextSar[i] = cmpKeep;
      if (i < W-1 && bitIdx == IDXW'(i+1)) nextSar[i] = 1'b1;
    end
  end

  generate
    if (BIPOLAR) begin : g_twos
      assign coded = {~sarReg[W-1], sarReg[W-2:0]};
    end else begin : g_bin
      assign coded = sarReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg   <= '0;
      outLatch <= '0;
    end else begin
      if (strobe.clearSar)     sarReg <= MSB_ONE;
      else if (strobe.stepBit) sarReg <= nextSar;
      if (strobe.loadOut)      outLatch <= coded;
    end
  end

  assign trialWord = sarReg;
  assign outWord   = byteSel ? {outLatch[HALF-1:0], outLatch[W-1:HALF]} : outLatch;
endmodule

// File: rtl/sarConvCore.sv
module sarConvCore
  import sarPkg::*;
#(
  parameter int W           = 16,
  parameter bit BIPOLAR     = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW       = $clog2(W)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rcN,
  input  logic         byteSel,
  input  logic         cmpKeep,
  output logic [W-1:0] dacWord,
  output logic         busyN,
  output logic [W-1:0] dataOut,
  output logic         busOe
);
  sarStrobe_t      strobe;
  logic [IDXW-1:0] bitIdx;

  sarCtrl #(.W(W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN),
    .strobe(strobe), .bitIdx(bitIdx), .busyN(busyN)
  );

  sarDatapath #(.W(W), .BIPOLAR(BIPOLAR)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .cmpKeep(cmpKeep), .byteSel(byteSel),
    .trialWord(dacWord), .outWord(dataOut)
  );

  assign busOe = ~csN & rcN;
endmodule

// File: rtl/sarConvCore_chk.sv
module sarConvCore_chk #(
  parameter int W = 16,
  localparam int CW = $clog2(W+2) + 1
) (
  input logic         clk,
  input logic         rstN,
  input logic         busyN,
  input logic [W-1:0] dacWord
);
  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      lowCnt <= '0;
    else if (!busyN) lowCnt <= lowCnt + 1'b1;
    else            lowCnt <= '0;
  end

  // R3
  first_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> dacWord == {1'b1, {(W-1){1'b0}}});

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && !$past(busyN)) |-> $countones(dacWord ^ $past(dacWord)) <= 2);

  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> lowCnt <= CW'(W));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> lowCnt == CW'(W+1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && $past(busyN)) |-> $stable(dacWord));
endmodule

bind sarConvCore sarConvCore_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .busyN(busyN), .dacWord(dacWord)
);

// File: tb/test_sarConvCore.sv
module test_sarConvCore;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, rcN = 1'b1, byteSel = 1'b0;
  logic [W-1:0] vinU = '0, vinS = '0;
  logic [W-1:0] dacU, dacB, dataU, dataB;
  logic busyU, busyB, oeU, oeB, cmpU, cmpB;
  int checks = 0, fails = 0, cyc = 0;
  int lowRun = 0, lastLow = 0, highRun = 0, lastHigh = 0;
  logic [W-1:0] firstDac = '0;

  assign cmpU = (dacU <= vinU);
  assign cmpB = (dacB <= (vinS ^ 16'h8000));

  sarConvCore #(.W(W), .BIPOLAR(1'b0)) i_sarConvCore (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .byteSel(byteSel),
    .cmpKeep(cmpU), .dacWord(dacU), .busyN(busyU), .dataOut(dataU), .busOe(oeU));

  sarConvCore #(.W(W), .BIPOLAR(1'b1)) i_sarConvCoreBip (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .byteSel(byteSel),
    .cmpKeep(cmpB), .dacWord(dacB), .busyN(busyB), .dataOut(dataB), .busOe(oeB));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN) begin
      if (!busyU) begin
        if (lowRun == 0) begin
          firstDac = dacU;
          lastHigh = highRun;
        end
        lowRun++;
        highRun = 0;
      end else begin
        if (lowRun != 0) lastLow = lowRun;
        lowRun = 0;
        highRun++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      summary();
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitFall();
    for (int i = 0; i < 20 && busyU; i++) tick();
  endtask

  task automatic waitRise();
    for (int i = 0; i < 40 && !busyU; i++) tick();
  endtask

  task automatic t_reset();
    chk("R10 busy", busyU, 1);
    chk("R10 dac", dacU, 0);
    chk("R7 oe with csN high", oeU, 0);
  endtask

  task automatic t_rcStart();
    vinU = 16'hA5C3; vinS = 16'hCFC7;
    csN = 1'b0; rcN = 1'b1;
    tick();
    chk("R7 oe read", oeU, 1);
    chk("R10 latch", dataU, 0);
    rcN = 1'b0;
    tick();
    chk("R7 oe rcN low", oeU, 0);
    waitFall();
    chk("R1 busy low", busyU, 0);
    chk("R1 bipolar busy low", busyB, 0);
    chk("R3 first trial", firstDac, 16'h8000);
    repeat (3) tick();
    rcN = 1'b1;
    tick();
    chk("R11 old data", dataU, 0);
    waitRise();
    chk("R4 busy length", lastLow, W+1);
    chk("R9 unipolar", dataU, 16'hA5C3);
    chk("R9 bipolar", dataB, 16'hCFC7);
  endtask

  task automatic t_csStart();
    csN = 1'b1; rcN = 1'b1;
    tick();
    rcN = 1'b0;
    repeat (5) tick();
    chk("R2 no start csN high", busyU, 1);
    vinU = 16'hFFFF; vinS = 16'h7FFF;
    csN = 1'b0;
    waitFall();
    chk("R2 start on csN", busyU, 0);
    tick();
    csN = 1'b1;
    waitRise();
    chk("R4 busy length cs", lastLow, W+1);
    rcN = 1'b1; csN = 1'b0;
    tick();
    chk("R9 full scale", dataU, 16'hFFFF);
    chk("R9 bipolar max", dataB, 16'h7FFF);
  endtask

  task automatic t_ignore();
    vinU = 16'h0000; vinS = 16'h8000;
    tick();
    rcN = 1'b0;
    waitFall();
    repeat (4) tick();
    rcN = 1'b1;
    repeat (2) tick();
    rcN = 1'b0;
    repeat (2) tick();
    rcN = 1'b1;
    waitRise();
    chk("R5 length kept", lastLow, W+1);
    repeat (10) tick();
    chk("R5 no second conv", busyU, 1);
    chk("R5 zero result", dataU, 16'h0000);
    chk("R9 bipolar min", dataB, 16'h8000);
  endtask

  task automatic t_retrig();
    vinU = 16'h1234; vinS = 16'h0001;
    rcN = 1'b0;
    waitFall();
    waitRise();
    chk("R6 rise seen", busyU, 1);
    vinU = 16'hBEEF; vinS = 16'h8001;
    tick();
    chk("R6 restart", busyU, 0);
    chk("R6 one idle cycle", lastHigh, 1);
    repeat (3) tick();
    rcN = 1'b1;
    waitRise();
    chk("R6 second length", lastLow, W+1);
    chk("R6 second result", dataU, 16'hBEEF);
    chk("R6 bipolar result", dataB, 16'h8001);
  endtask

  task automatic t_bytes();
    csN = 1'b0; rcN = 1'b1; byteSel = 1'b1;
    tick();
    chk("R8 swapped", dataU, 16'hEFBE);
    chk("R8 swapped bip", dataB, 16'h0180);
    byteSel = 1'b0;
    tick();
    chk("R8 normal", dataU, 16'hBEEF);
    csN = 1'b1;
    tick();
    chk("R7 oe off", oeU, 0);
  endtask

  initial begin
    repeat (4) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_rcStart();
    t_csStart();
    t_ignore();
    t_retrig();
    t_bytes();
    summary();
  end
endmodule